// File: doc/BRIEF.md
# Control Register Bank with Bit Set, Clear and Toggle Aliases

This block holds a small bank of 32-bit control registers behind a simple single-cycle bus slave. Each register sits in a 16-byte slot made of four word addresses. The word at offset 0x0 is the ordinary read/write view. A write to offset 0x4 ORs the write data into the register. A write to offset 0x8 clears the bits where the data is 1, and a write to offset 0xC inverts them. Software can therefore flip single bits in one bus write, with no read-modify-write race against other agents.

Parameters set the following for each register: its reset value, whether the three alias words exist, which bits may hold data (a narrow 8-bit register keeps only its low byte), and which bits are protected. A protected bit cannot be changed by a plain write or by a toggle. It moves only through the set or clear alias. The register contents are driven out continuously so that the surrounding logic can use them.

Top module: `regbank_sct`

## Requirements
- R1: On synchronous active-high `rst`, every register loads its parameter reset value. The defaults are reg0=0x000000A5, reg1=0x00000000, reg2=0x0000003C and reg3=0x12345678.
- R2: A write to slot offset 0x0 replaces every unprotected bit with the write data. A register changes only on a clock edge where `wrEn` is high.
- R3: A write to offset 0x4 of a register with aliases sets each bit whose data bit is 1. All other bits keep their value.
- R4: A write to offset 0x8 of a register with aliases clears each bit whose data bit is 1. All other bits keep their value.
- R5: A write to offset 0xC of a register with aliases inverts each unprotected bit whose data bit is 1.
- R6: Protected bits keep their value on writes to offset 0x0 and offset 0xC. They do change through offsets 0x4 and 0x8. By default reg1 bits 31:28 are protected.
- R7: For a register built without aliases (by default reg3, slot 0x30), writes to offsets 0x4, 0x8 and 0xC have no effect, and reads at those offsets return zero.
- R8: An 8-bit register (by default reg2, slot 0x20) stores only bits 7:0. Bits 31:8 always read as zero.
- R9: A read at any of the four offsets of a register with aliases returns that register's current value.
- R10: An address at or above NUM_REGS*16 (0x40 by default) is ignored for writes and reads as zero.
- R11: Read data is registered and appears one cycle after `rdEn`. It is zero after a cycle without `rdEn`. A read in the same cycle as a write to the same register returns the old value. A new access is accepted every cycle.
- R12: Address bits 1:0 are ignored. Register n's slot starts at byte address n*16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the current cycle |
| rdEn | input | 1 | Read strobe for the current cycle |
| addr | input | ADDR_W (8) | Byte address of the access |
| wrData | input | 32 | Write data or bit mask |
| rdData | output | 32 | Registered read data |
| regOut | output | NUM_REGS*32 (128) | All register values; register n occupies bits n*32+31 down to n*32 |

## Verification
The hardest case to reach is a protected bit that has to change. A plain write cannot move it, so the stimulus first sets the protected nibble of reg1 through the set alias. It then issues full-ones plain writes and a toggle, and finally clears one protected bit through the clear alias. This shows the bit both holding its value and moving. A second awkward case is a read and a write to the same word in the same cycle. The bench drives both strobes together and expects the value from before the write, and only after that looks at the updated register output.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_SET   = 2'd1,
    KIND_CLR   = 2'd2,
    KIND_TOG   = 2'd3
  } accessKind_e;

  typedef struct packed {
    logic              hit;
    logic              wr;
    logic              rd;
    accessKind_e       kind;
    logic [IDX_W-1:0]  regIdx;
  } bankStrobe_t;
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter logic [NUM_REGS-1:0] ALIAS_EN = '1
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output bankStrobe_t       strobe
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slotNum;
  accessKind_e       kind;
  logic              inRange;
  logic              aliasOk;

  assign slotNum = addr[ADDR_W-1:4];
  assign kind    = accessKind_e'(addr[3:2]);
  assign inRange = (int'(slotNum) < NUM_REGS);

  always_comb begin
    aliasOk = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(slotNum) == i) aliasOk = ALIAS_EN[i];
    end
  end

  always_comb begin
    strobe.hit    = inRange && ((kind == KIND_PLAIN) || aliasOk);
    strobe.wr     = wrEn;
    strobe.rd     = rdEn;
    strobe.kind   = kind;
    strobe.regIdx = IDX_W'(slotNum);
  end
endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*32-1:0] RESET_VALS  = '0,
  parameter logic [NUM_REGS*32-1:0] LOCK_MASKS  = '0,
  parameter logic [NUM_REGS*32-1:0] WIDTH_MASKS = '1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  bankStrobe_t            strobe,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  output logic [NUM_REGS*32-1:0] regOut
);
  function automatic logic [31:0] applyOp(
    input logic [31:0] cur,
    input logic [31:0] wd,
    input logic [31:0] lock,
    input accessKind_e kind
  );
    case (kind)
      KIND_PLAIN: applyOp = (cur & lock) | (wd & ~lock);
      KIND_SET:   applyOp = cur | wd;
      KIND_CLR:   applyOp = cur & ~wd;
      default:    applyOp = cur ^ (wd & ~lock);
    endcase
  endfunction

  logic [31:0] regQ [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [31:0] RST_V  = RESET_VALS[g*32 +: 32];
    localparam logic [31:0] LOCK_V = LOCK_MASKS[g*32 +: 32];
    localparam logic [31:0] WID_V  = WIDTH_MASKS[g*32 +: 32];
    logic writeHere;

    assign writeHere = strobe.wr && strobe.hit && (int'(strobe.regIdx) == g);

    always_ff @(posedge clk) begin
      if (rst) begin
        regQ[g] <= RST_V & WID_V;
      end else if (writeHere) begin
        regQ[g] <= applyOp(regQ[g], wrData, LOCK_V, strobe.kind) & WID_V;
      end
    end

    assign regOut[g*32 +: 32] = regQ[g];
  end

  logic [31:0] readMux;
  always_comb begin
    readMux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobe.hit && int'(strobe.regIdx) == i) readMux = regQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else     rdData <= strobe.rd ? readMux : '0;
  end
endmodule

// File: rtl/regbank_sct.sv
module regbank_sct
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter logic [NUM_REGS-1:0] ALIAS_EN = 4'b0111,
  parameter logic [NUM_REGS*32-1:0] RESET_VALS =
    {32'h1234_5678, 32'h0000_003C, 32'h0000_0000, 32'h0000_00A5},
  parameter logic [NUM_REGS*32-1:0] LOCK_MASKS =
    {32'h0000_0000, 32'h0000_0000, 32'hF000_0000, 32'h0000_0000},
  parameter logic [NUM_REGS*32-1:0] WIDTH_MASKS =
    {32'hFFFF_FFFF, 32'h0000_00FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  output logic [NUM_REGS*32-1:0] regOut
);
  bankStrobe_t strobe;

  regbank_ctrl #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .ALIAS_EN(ALIAS_EN)
  ) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strobe(strobe)
  );

  regbank_dp #(
    .NUM_REGS(NUM_REGS), .RESET_VALS(RESET_VALS),
    .LOCK_MASKS(LOCK_MASKS), .WIDTH_MASKS(WIDTH_MASKS)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .regOut(regOut)
  );
endmodule

// File: rtl/regbank_sct_chk.sv
module regbank_sct_chk #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter logic [NUM_REGS*32-1:0] RESET_VALS  = '0,
  parameter logic [NUM_REGS*32-1:0] LOCK_MASKS  = '0,
  parameter logic [NUM_REGS*32-1:0] WIDTH_MASKS = '1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wrEn,
  input logic                   rdEn,
  input logic [ADDR_W-1:0]      addr,
  input logic [31:0]            rdData,
  input logic [NUM_REGS*32-1:0] regOut
);
  assert_reset_values_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regOut == (RESET_VALS & WIDTH_MASKS)));

  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(regOut));

  assert_protected_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (addr[3:2] == 2'd0 || addr[3:2] == 2'd3))
      |=> (((regOut ^ $past(regOut)) & LOCK_MASKS) == '0));

  assert_narrow_width_R8: assert property (@(posedge clk) disable iff (rst)
    (regOut & ~WIDTH_MASKS) == '0);

  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
    (wrEn && int'(addr) >= NUM_REGS*16) |=> $stable(regOut));

  assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> (rdData == '0));
endmodule

bind regbank_sct regbank_sct_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .RESET_VALS(RESET_VALS),
  .LOCK_MASKS(LOCK_MASKS), .WIDTH_MASKS(WIDTH_MASKS)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .rdData(rdData), .regOut(regOut)
);

// File: tb/test_regbank_sct.sv
module test_regbank_sct;
  localparam int NUM_REGS = 4;
  localparam int ADDR_W   = 8;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   wrEn = 1'b0;
  logic                   rdEn = 1'b0;
  logic [ADDR_W-1:0]      addr = '0;
  logic [31:0]            wrData = '0;
  logic [31:0]            rdData;
  logic [NUM_REGS*32-1:0] regOut;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  regbank_sct i_regbank_sct (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .regOut(regOut)
  );

  // vector: {isWrite, addr[7:0], data[31:0] (write data or expected read), reqNum[3:0]}
  localparam int NUM_VEC = 34;
  localparam logic [44:0] VEC [NUM_VEC] = '{
    {1'b0, 8'h00, 32'h0000_00A5, 4'd1},   // R1 reset reg0
    {1'b0, 8'h30, 32'h1234_5678, 4'd1},   // R1 reset reg3
    {1'b1, 8'h00, 32'hDEAD_BEEF, 4'd2},
    {1'b0, 8'h00, 32'hDEAD_BEEF, 4'd2},   // R2 plain write
    {1'b1, 8'h04, 32'h0000_0F00, 4'd3},
    {1'b0, 8'h04, 32'hDEAD_BFEF, 4'd3},   // R3 set, R9 alias read
    {1'b1, 8'h08, 32'h0000_00FF, 4'd4},
    {1'b0, 8'h08, 32'hDEAD_BF00, 4'd4},   // R4 clear
    {1'b1, 8'h0C, 32'hFFFF_0000, 4'd5},
    {1'b0, 8'h0C, 32'h2152_BF00, 4'd5},   // R5 toggle
    {1'b1, 8'h10, 32'hFFFF_FFFF, 4'd6},
    {1'b0, 8'h10, 32'h0FFF_FFFF, 4'd6},   // R6 protected nibble held
    {1'b1, 8'h14, 32'h3000_0000, 4'd6},
    {1'b0, 8'h10, 32'h3FFF_FFFF, 4'd6},   // R6 set reaches protected bits
    {1'b1, 8'h1C, 32'hF000_0001, 4'd5},
    {1'b0, 8'h10, 32'h3FFF_FFFE, 4'd5},   // R5 toggle skips protected bits
    {1'b1, 8'h18, 32'h1000_0000, 4'd6},
    {1'b1, 8'h10, 32'h0000_0000, 4'd6},
    {1'b0, 8'h10, 32'h2000_0000, 4'd6},   // R6 clear reaches, plain write does not
    {1'b1, 8'h20, 32'hAABB_CCDD, 4'd8},
    {1'b0, 8'h20, 32'h0000_00DD, 4'd8},   // R8 low byte only
    {1'b1, 8'h2C, 32'hFFFF_FFFF, 4'd8},
    {1'b0, 8'h24, 32'h0000_0022, 4'd9},   // R9 read via set alias, R8 narrow toggle
    {1'b0, 8'h2C, 32'h0000_0022, 4'd9},   // R9 read via toggle alias
    {1'b1, 8'h34, 32'hFFFF_FFFF, 4'd7},
    {1'b1, 8'h38, 32'hFFFF_FFFF, 4'd7},
    {1'b1, 8'h3C, 32'h0000_0001, 4'd7},
    {1'b0, 8'h30, 32'h1234_5678, 4'd7},   // R7 no-alias register untouched
    {1'b0, 8'h34, 32'h0000_0000, 4'd7},   // R7 missing alias reads zero
    {1'b1, 8'h40, 32'hFFFF_FFFF, 4'd10},
    {1'b1, 8'hFC, 32'hFFFF_FFFF, 4'd10},
    {1'b0, 8'h40, 32'h0000_0000, 4'd10},  // R10 unmapped reads zero
    {1'b1, 8'h03, 32'h1111_1111, 4'd12},
    {1'b0, 8'h02, 32'h1111_1111, 4'd12}   // R12 low address bits ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state on the outputs
    check("R1", regOut[31:0],   32'h0000_00A5);
    check("R1", regOut[63:32],  32'h0000_0000);
    check("R1", regOut[95:64],  32'h0000_003C);
    check("R1", regOut[127:96], 32'h1234_5678);
    check("R11", rdData, 32'h0);

    for (int i = 0; i < NUM_VEC; i++) begin
      access(VEC[i][44], !VEC[i][44], VEC[i][43:36], VEC[i][35:4]);
      if (!VEC[i][44]) check($sformatf("R%0d", VEC[i][3:0]), rdData, VEC[i][35:4]);
    end

    // R10 unmapped writes left reg0 as written at vector stage
    check("R10", regOut[31:0], 32'h1111_1111);
    check("R8", regOut[95:64], 32'h0000_0022);
    check("R7", regOut[127:96], 32'h1234_5678);

    // R11 idle read data is zero
    @(negedge clk);
    check("R11", rdData, 32'h0);

    // R11 read and write same word in one cycle: old value returned
    access(1'b1, 1'b1, 8'h00, 32'h0000_0055);
    check("R11", rdData, 32'h1111_1111);
    check("R2", regOut[31:0], 32'h0000_0055);

    // R11 back-to-back reads on consecutive cycles
    @(negedge clk);
    rdEn = 1'b1; addr = 8'h00;
    @(negedge clk);
    check("R11", rdData, 32'h0000_0055);
    addr = 8'h10;
    @(negedge clk);
    check("R11", rdData, 32'h2000_0000);
    rdEn = 1'b0;

    // R1 reset in mid run restores everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", regOut[31:0],   32'h0000_00A5);
    check("R1", regOut[63:32],  32'h0000_0000);
    check("R1", regOut[95:64],  32'h0000_003C);
    check("R1", regOut[127:96], 32'h1234_5678);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule